// File: doc/BRIEF.md
# bfloat16 Dual-Path Adder

This block adds or subtracts two 16-bit brain-float operands. Each operand has a sign bit in bit 15, an 8-bit biased exponent in bits 14:7 (bias 127) and a 7-bit fraction in bits 6:0 with an implied leading one. The operation select negates the second operand before the addition. The result is captured in an output register on the rising clock edge where the operands are sampled, so it can be read one cycle after the inputs are applied.

The operands are first ordered by magnitude. The sum then goes down one of two separate datapaths. The close path handles effective subtractions whose exponents differ by zero or one. It subtracts exactly, then finds the leading one with a flat priority encoder and shifts left to normalise. The far path handles every other case. It aligns the smaller operand to the right, keeping guard bits and a sticky bit, then adds or subtracts and corrects the result by at most one position.

Rounding is toward zero and gives the exact truncation of the true sum. The block does not support NaN, infinity or subnormal values. A zero exponent field reads as zero, results that are too small flush to a signed zero, and results that are too large clamp to the largest finite magnitude.

Top module: `bf16_dual_path_adder`

## Requirements
- R1: `sum` shows the result for the operands and `sub` that were sampled at the previous rising edge and holds it until the next edge. While `rst_n` is low, `sum` is 16'h0000, and this is forced asynchronously.
- R2: For two nonzero operands with the same effective sign, `sum` is the exact sum truncated toward zero, including the case where a carry-out raises the exponent by one.
- R3: For an effective subtraction whose exponent fields differ by 2 or more, `sum` is the exact difference truncated toward zero. Its magnitude never exceeds the true magnitude. For example, 16'h3F80 minus 16'h3A80 gives 16'h3F7F.
- R4: For an effective subtraction whose exponent fields differ by 0 or 1, `sum` is the exact difference, normalised across up to 8 leading zero positions and truncated toward zero.
- R5: With `sub`=1 the block computes `opa` minus `opb`, which is the same as inverting bit 15 of `opb` and adding. With `sub`=0 it computes `opa` plus `opb`.
- R6: A nonzero result takes the sign of the operand with the larger magnitude after the `sub` negation. An exact cancellation of two nonzero operands returns 16'h0000.
- R7: An operand whose exponent field is 0 counts as zero, whatever its fraction bits hold. If exactly one operand is zero, the other operand is returned with its effective sign. If both are zero, the result is 16'h8000 only when both effective signs are negative, and 16'h0000 otherwise.
- R8: A result whose biased exponent would fall below 1 is returned as a zero with the result sign: 16'h0000 or 16'h8000.
- R9: An exponent field of 255 on an input is treated as an ordinary finite value. A result whose biased exponent would exceed 254 is clamped to the result sign with exponent 8'hFE and fraction 7'h7F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; operands are sampled and the result is registered on the rising edge |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released synchronously |
| opa | input | 16 | First operand, bfloat16 |
| opb | input | 16 | Second operand, bfloat16 |
| sub | input | 1 | 1 = subtract `opb` from `opa`, 0 = add |
| sum | output | 16 | Registered bfloat16 result |

## Verification
Two situations are the hardest to reach with random operand pairs. The first is close-path cancellation of almost equal operands, which leaves many leading zeros to remove. The second is a far-path subtraction where discarded bits must pull the truncated result down by one unit in the last place. Independent random operands almost never produce either one. The stimulus therefore derives half of its pairs from the first operand: the exponent stays equal or drops by one, the upper fraction bits are copied, and the sign is arranged so that the operation is an effective subtraction. A fixed table adds hand-computed cases for a single surviving bit, for a far subtraction that truncates to 16'h3F7F, and for underflow and saturation.

// File: rtl/bf16_add_pkg.sv
`timescale 1ns/1ps
package bf16_add_pkg;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 7;
  localparam int SIG_W  = MAN_W + 1;
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int EXPR_W = EXP_W + 2;

  localparam logic [EXP_W-1:0] EXP_ALL1 = {EXP_W{1'b1}};
  localparam logic [EXP_W-1:0] EXP_SAT  = EXP_ALL1 - EXP_W'(1);

  typedef struct packed {
    logic             sgn;
    logic [EXP_W-1:0] exp;
    logic [MAN_W-1:0] man;
  } bf16_t;

  typedef struct packed {
    logic             sgn;
    logic             zero;
    logic [EXP_W-1:0] exp;
    logic [SIG_W-1:0] sig;
  } opnd_t;
endpackage

// File: rtl/bf16_operand_sort.sv
`timescale 1ns/1ps
module bf16_operand_sort
  import bf16_add_pkg::*;
(
  input  bf16_t            op_a_i,
  input  bf16_t            op_b_i,
  input  logic             sub_i,
  output opnd_t            big_o,
  output logic             small_sgn_o,
  output logic             small_zero_o,
  output logic [SIG_W-1:0] small_sig_o,
  output logic [EXP_W-1:0] shamt_o,
  output logic             eff_sub_o
);
  opnd_t ua, ub, sm;
  logic [EXP_W+MAN_W-1:0] key_a, key_b;
  logic swap;

  always_comb begin
    // unpack; a zero exponent field means zero regardless of fraction
    ua.sgn  = op_a_i.sgn;
    ua.zero = (op_a_i.exp == '0);
    ua.exp  = op_a_i.exp;
    ua.sig  = ua.zero ? '0 : {1'b1, op_a_i.man};
    ub.sgn  = op_b_i.sgn ^ sub_i;
    ub.zero = (op_b_i.exp == '0);
    ub.exp  = op_b_i.exp;
    ub.sig  = ub.zero ? '0 : {1'b1, op_b_i.man};

    // magnitude keys: exponent then fraction, zero maps to smallest
    key_a = ua.zero ? '0 : {op_a_i.exp, op_a_i.man};
    key_b = ub.zero ? '0 : {op_b_i.exp, op_b_i.man};
    swap  = (key_b > key_a);

    big_o = swap ? ub : ua;
    sm    = swap ? ua : ub;

    small_sgn_o  = sm.sgn;
    small_zero_o = sm.zero;
    small_sig_o  = sm.sig;
    shamt_o      = big_o.exp - sm.exp;
    eff_sub_o    = big_o.sgn ^ sm.sgn;
  end
endmodule

// File: rtl/bf16_far_path.sv
`timescale 1ns/1ps
module bf16_far_path
  import bf16_add_pkg::*;
#(
  parameter int GRD_W = 3   // guard positions below the significand, at least 2
) (
  input  logic                     [SIG_W-1:0]  big_sig_i,
  input  logic                     [SIG_W-1:0]  small_sig_i,
  input  logic                     [EXP_W-1:0]  big_exp_i,
  input  logic                     [EXP_W-1:0]  shamt_i,
  input  logic                                  eff_sub_i,
  output logic                     [MAN_W-1:0]  man_o,
  output logic signed              [EXPR_W-1:0] exp_o
);
  localparam int XW = SIG_W + GRD_W;
  localparam logic signed [EXPR_W-1:0] ONE = EXPR_W'(1);

  logic [XW-1:0] big_x, small_x, aligned, lost_mask;
  logic          sticky;
  logic [XW:0]   raw;
  logic signed [EXPR_W-1:0] exp_base;
  logic unused_far_lsbs;

  always_comb begin
    big_x   = {big_sig_i,   {GRD_W{1'b0}}};
    small_x = {small_sig_i, {GRD_W{1'b0}}};

    // right alignment, bits pushed out collapse into one sticky flag
    if (shamt_i >= EXP_W'(XW)) begin
      aligned   = '0;
      lost_mask = '1;
    end else begin
      aligned   = small_x >> shamt_i;
      lost_mask = ~({XW{1'b1}} << shamt_i);
    end
    sticky = |(small_x & lost_mask);

    // subtracting the sticky keeps truncation exact toward zero
    if (eff_sub_i) raw = {1'b0, big_x} - {1'b0, aligned} - {{XW{1'b0}}, sticky};
    else           raw = {1'b0, big_x} + {1'b0, aligned};

    exp_base = $signed({2'b00, big_exp_i});
    if (raw[XW]) begin
      man_o = raw[XW-1 -: MAN_W];
      exp_o = exp_base + ONE;
    end else if (raw[XW-1]) begin
      man_o = raw[XW-2 -: MAN_W];
      exp_o = exp_base;
    end else begin
      man_o = raw[XW-3 -: MAN_W];
      exp_o = exp_base - ONE;
    end
  end

  assign unused_far_lsbs = ^raw[GRD_W-2:0];
endmodule

// File: rtl/bf16_close_path.sv
`timescale 1ns/1ps
module bf16_close_path
  import bf16_add_pkg::*;
(
  input  logic                [SIG_W-1:0]  big_sig_i,
  input  logic                [SIG_W-1:0]  small_sig_i,
  input  logic                [EXP_W-1:0]  big_exp_i,
  input  logic                             one_apart_i,
  output logic                [MAN_W-1:0]  man_o,
  output logic signed         [EXPR_W-1:0] exp_o,
  output logic                             cancel_o
);
  localparam int DW   = SIG_W + 1;
  localparam int LZ_W = $clog2(DW + 1);

  logic [DW-1:0]   lhs, rhs, dif, norm;
  logic [LZ_W-1:0] lz;
  logic unused_close_bits;

  always_comb begin
    lhs = {big_sig_i, 1'b0};
    rhs = one_apart_i ? {1'b0, small_sig_i} : {small_sig_i, 1'b0};
    dif = lhs - rhs;

    // flat priority encode: highest set bit wins, no tree
    lz = LZ_W'(DW);
    for (int i = 0; i < DW; i++) begin
      if (dif[i]) lz = LZ_W'(DW - 1 - i);
    end

    norm     = dif << lz;
    man_o    = norm[DW-2 -: MAN_W];
    exp_o    = $signed({2'b00, big_exp_i}) - $signed({{(EXPR_W-LZ_W){1'b0}}, lz});
    cancel_o = (dif == '0);
  end

  assign unused_close_bits = norm[DW-1] ^ norm[0];
endmodule

// File: rtl/bf16_result_pack.sv
`timescale 1ns/1ps
module bf16_result_pack
  import bf16_add_pkg::*;
(
  input  logic                    big_sgn_i,
  input  logic                    big_zero_i,
  input  logic        [EXP_W-1:0] big_exp_i,
  input  logic        [MAN_W-1:0] big_man_i,
  input  logic                    small_sgn_i,
  input  logic                    small_zero_i,
  input  logic                    use_close_i,
  input  logic        [MAN_W-1:0] far_man_i,
  input  logic signed [EXPR_W-1:0] far_exp_i,
  input  logic        [MAN_W-1:0] close_man_i,
  input  logic signed [EXPR_W-1:0] close_exp_i,
  input  logic                    close_cancel_i,
  output bf16_t                   res_o
);
  localparam logic signed [EXPR_W-1:0] EXP_LO = EXPR_W'(1);
  localparam logic signed [EXPR_W-1:0] EXP_HI = $signed({2'b00, EXP_SAT});

  logic                     res_sgn, force_zero;
  logic [MAN_W-1:0]         man_sel;
  logic signed [EXPR_W-1:0] exp_sel;

  always_comb begin
    res_sgn    = big_sgn_i;
    force_zero = 1'b0;
    man_sel    = far_man_i;
    exp_sel    = far_exp_i;
    if (big_zero_i) begin
      force_zero = 1'b1;
      res_sgn    = big_sgn_i & small_sgn_i;
    end else if (small_zero_i) begin
      man_sel = big_man_i;
      exp_sel = $signed({2'b00, big_exp_i});
    end else if (use_close_i) begin
      if (close_cancel_i) begin
        force_zero = 1'b1;
        res_sgn    = 1'b0;
      end else begin
        man_sel = close_man_i;
        exp_sel = close_exp_i;
      end
    end

    res_o.sgn = res_sgn;
    if (force_zero || (exp_sel < EXP_LO)) begin
      res_o.exp = '0;
      res_o.man = '0;
    end else if (exp_sel > EXP_HI) begin
      res_o.exp = EXP_SAT;
      res_o.man = '1;
    end else begin
      res_o.exp = exp_sel[EXP_W-1:0];
      res_o.man = man_sel;
    end
  end
endmodule

// File: rtl/bf16_dual_path_adder.sv
`timescale 1ns/1ps
module bf16_dual_path_adder
  import bf16_add_pkg::*;
#(
  parameter int GRD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  input  logic              sub,
  output logic [WORD_W-1:0] sum
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  opnd_t                    big;
  logic                     small_sgn, small_zero, eff_sub, use_close;
  logic [SIG_W-1:0]         small_sig;
  logic [EXP_W-1:0]         shamt;
  logic [MAN_W-1:0]         far_man, close_man;
  logic signed [EXPR_W-1:0] far_exp, close_exp;
  logic                     close_cancel;
  bf16_t                    sum_d;
  logic [WORD_W-1:0]        sum_q;

  bf16_operand_sort u_sort (
    .op_a_i       (opa),
    .op_b_i       (opb),
    .sub_i        (sub),
    .big_o        (big),
    .small_sgn_o  (small_sgn),
    .small_zero_o (small_zero),
    .small_sig_o  (small_sig),
    .shamt_o      (shamt),
    .eff_sub_o    (eff_sub)
  );

  assign use_close = eff_sub && (shamt <= EXP_W'(1));

  bf16_far_path #(.GRD_W(GRD_W)) u_far (
    .big_sig_i   (big.sig),
    .small_sig_i (small_sig),
    .big_exp_i   (big.exp),
    .shamt_i     (shamt),
    .eff_sub_i   (eff_sub),
    .man_o       (far_man),
    .exp_o       (far_exp)
  );

  bf16_close_path u_close (
    .big_sig_i   (big.sig),
    .small_sig_i (small_sig),
    .big_exp_i   (big.exp),
    .one_apart_i (shamt[0]),
    .man_o       (close_man),
    .exp_o       (close_exp),
    .cancel_o    (close_cancel)
  );

  bf16_result_pack u_pack (
    .big_sgn_i      (big.sgn),
    .big_zero_i     (big.zero),
    .big_exp_i      (big.exp),
    .big_man_i      (big.sig[MAN_W-1:0]),
    .small_sgn_i    (small_sgn),
    .small_zero_i   (small_zero),
    .use_close_i    (use_close),
    .far_man_i      (far_man),
    .far_exp_i      (far_exp),
    .close_man_i    (close_man),
    .close_exp_i    (close_exp),
    .close_cancel_i (close_cancel),
    .res_o          (sum_d)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) sum_q <= '0;
    else          sum_q <= sum_d;
  end

  assign sum = sum_q;
endmodule

// File: rtl/bf16_add_checker.sv
`timescale 1ns/1ps
module bf16_add_checker
  import bf16_add_pkg::*;
(
  input logic              clk,
  input logic              rst_q_n,
  input logic [WORD_W-1:0] opa,
  input logic [WORD_W-1:0] opb,
  input logic              sub,
  input logic [WORD_W-1:0] sum
);
  localparam int EH = WORD_W - 2;
  localparam int SB = WORD_W - 1;

  logic a_zero, b_zero, a_ok, b_ok, b_eff_sgn;
  assign a_zero    = (opa[EH -: EXP_W] == '0);
  assign b_zero    = (opb[EH -: EXP_W] == '0);
  assign a_ok      = !a_zero && (opa[EH -: EXP_W] != EXP_ALL1);
  assign b_ok      = !b_zero && (opb[EH -: EXP_W] != EXP_ALL1);
  assign b_eff_sgn = opb[SB] ^ sub;

  // R7: zero second operand passes the first through
  a_r7_zero_b_passes_a: assert property (@(posedge clk) disable iff (!rst_q_n)
    (b_zero && a_ok) |=> (sum == $past(opa)));

  // R7: zero first operand passes the effective second operand through
  a_r7_zero_a_passes_b: assert property (@(posedge clk) disable iff (!rst_q_n)
    (a_zero && b_ok) |=> (sum == {$past(b_eff_sgn), $past(opb[SB-1:0])}));

  // R6: exact cancellation returns positive zero
  a_r6_cancel_pos_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!a_zero && (opa[SB-1:0] == opb[SB-1:0]) && (opa[SB] != b_eff_sgn)) |=> (sum == '0));

  // R2: like-signed nonzero operands keep their sign
  a_r2_like_sign_kept: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!a_zero && !b_zero && (opa[SB] == b_eff_sgn)) |=> (sum[SB] == $past(opa[SB])));

  // R8: no subnormal pattern ever leaves the block
  a_r8_no_subnormal: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sum[EH -: EXP_W] == '0) |-> (sum[MAN_W-1:0] == '0));

  // R9: the all-ones exponent is never produced
  a_r9_no_top_exp: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sum[EH -: EXP_W] != EXP_ALL1));
endmodule

bind bf16_dual_path_adder bf16_add_checker u_chk (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .opa     (opa),
  .opb     (opb),
  .sub     (sub),
  .sum     (sum)
);

// File: tb/bf16_dual_path_adder_tb.sv
`timescale 1ns/1ps
module bf16_dual_path_adder_tb;
  logic        clk;
  logic        rst_n;
  logic [15:0] opa, opb;
  logic        sub;
  logic [15:0] sum;

  int n_cmp;
  int n_bad;
  logic done;

  bf16_dual_path_adder u_dut (
    .clk   (clk),
    .rst_n (rst_n),
    .opa   (opa),
    .opb   (opb),
    .sub   (sub),
    .sum   (sum)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  // {opa, opb, sub, expected}
  localparam int NV = 21;
  localparam logic [48:0] VEC [NV] = '{
    {16'h3F80, 16'h3F80, 1'b0, 16'h4000},
    {16'h3F80, 16'h3F80, 1'b1, 16'h0000},
    {16'h3FC0, 16'h3F80, 1'b0, 16'h4020},
    {16'h3F80, 16'h3F81, 1'b1, 16'hBC00},
    {16'h3F80, 16'h3A80, 1'b0, 16'h3F80},
    {16'h3F80, 16'h3A80, 1'b1, 16'h3F7F},
    {16'h4000, 16'h0080, 1'b0, 16'h4000},
    {16'h4000, 16'h0080, 1'b1, 16'h3FFF},
    {16'h7F7F, 16'h7F7F, 1'b0, 16'h7F7F},
    {16'h0080, 16'h0081, 1'b1, 16'h8000},
    {16'h0000, 16'hC040, 1'b0, 16'hC040},
    {16'h8000, 16'h8000, 1'b1, 16'h0000},
    {16'h8000, 16'h8000, 1'b0, 16'h8000},
    {16'h0005, 16'h3F80, 1'b0, 16'h3F80},
    {16'h4000, 16'h3FFF, 1'b1, 16'h3C00},
    {16'h4040, 16'hC000, 1'b1, 16'h40A0},
    {16'h3FFF, 16'h3FFF, 1'b0, 16'h407F},
    {16'h7F00, 16'h7F00, 1'b0, 16'h7F7F},
    {16'h7F80, 16'h3F80, 1'b0, 16'h7F7F},
    {16'h3F80, 16'h3F7F, 1'b1, 16'h3B80},
    {16'hC000, 16'h3F80, 1'b0, 16'hBF80}
  };
  localparam string TAG [NV] = '{
    "R2", "R6", "R2", "R4", "R2", "R3", "R2", "R3", "R9", "R8", "R7",
    "R7", "R7", "R7", "R4", "R5", "R2", "R9", "R9", "R4", "R6"
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: opa=%h opb=%h sub=%b actual=%h expected=%h", tag, opa, opb, sub, act, exp);
    end
  endtask

  // exact-arithmetic model, truncated toward zero
  function automatic logic [15:0] ref_add(input logic [15:0] a, input logic [15:0] b, input logic s);
    logic sa, sb, rs;
    logic [7:0] ea, eb;
    logic [271:0] va, vb, m;
    int emin, p, er;
    logic [6:0] mf;
    sa = a[15]; sb = b[15] ^ s; ea = a[14:7]; eb = b[14:7];
    if (ea == 0 && eb == 0) return {sa & sb, 15'h0};
    emin = (ea == 0) ? int'(eb) : (eb == 0) ? int'(ea) : ((ea < eb) ? int'(ea) : int'(eb));
    va = (ea == 0) ? '0 : ({264'b0, 1'b1, a[6:0]} << (int'(ea) - emin));
    vb = (eb == 0) ? '0 : ({264'b0, 1'b1, b[6:0]} << (int'(eb) - emin));
    if (sa == sb) begin m = va + vb; rs = sa; end
    else if (va >= vb) begin m = va - vb; rs = sa; end
    else begin m = vb - va; rs = sb; end
    if (m == '0) return 16'h0000;
    p = 0;
    for (int i = 0; i < 272; i++) if (m[i]) p = i;
    er = p + emin - 7;
    if (p >= 7) mf = 7'(m >> (p - 7));
    else        mf = 7'(m << (7 - p));
    if (er < 1)   return {rs, 15'h0};
    if (er > 254) return {rs, 8'hFE, 7'h7F};
    return {rs, 8'(er), mf};
  endfunction

  function automatic string class_tag(input logic [15:0] a, input logic [15:0] b, input logic s);
    int d;
    if (a[14:7] == 0 || b[14:7] == 0) return "R7";
    if (a[15] == (b[15] ^ s)) return "R2";
    d = (a[14:7] > b[14:7]) ? int'(a[14:7] - b[14:7]) : int'(b[14:7] - a[14:7]);
    return (d <= 1) ? "R4" : "R3";
  endfunction

  logic [31:0] rnd;
  function automatic logic [31:0] step(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    rnd = 32'h1BADF00D;
    rst_n = 1'b0;
    opa = 16'h3F80; opb = 16'h3F80; sub = 1'b0;

    // R1: reset clears the output
    repeat (3) @(negedge clk);
    chk("R1 reset", sum, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table of directed vectors
    for (int i = 0; i < NV; i++) begin
      {opa, opb, sub} = VEC[i][48:16];
      @(negedge clk);
      chk(TAG[i], sum, VEC[i][15:0]);
    end

    // R1: one-cycle latency, result held until the next edge
    opa = 16'h3F80; opb = 16'h3F80; sub = 1'b0;
    @(negedge clk);
    chk("R1 latency", sum, 16'h4000);
    opa = 16'h3FC0;
    #1;
    chk("R1 hold", sum, 16'h4000);
    @(negedge clk);
    chk("R1 update", sum, 16'h4020);

    // R5: the same pair with sub toggled
    opa = 16'h4040; opb = 16'h4000; sub = 1'b1;
    @(negedge clk);
    chk("R5 sub", sum, 16'h3F80);
    sub = 1'b0;
    @(negedge clk);
    chk("R5 add", sum, 16'h40A0);

    // R1: asynchronous assertion of reset mid-run
    #0.5 rst_n = 1'b0;
    #0.5 chk("R1 async reset", sum, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after reset", sum, 16'h40A0);

    // random and correlated sweep against the exact model
    for (int k = 0; k < 4000; k++) begin
      logic [15:0] ra, rb;
      logic [7:0] eb;
      rnd = step(rnd);
      ra = rnd[15:0];
      if (k[0]) begin
        rb = rnd[31:16];
      end else begin
        eb = ra[14:7] - {7'b0, rnd[16]};
        if (eb == 0) eb = 8'd1;
        rb[14:7] = eb;
        rb[6:0]  = rnd[17] ? (ra[6:0] ^ (rnd[23:17] & 7'h07)) : rnd[26:20];
        rb[15]   = ra[15] ^ rnd[27] ^ 1'b1;
        if (ra[14:7] == 0) ra[14:7] = 8'd1;
      end
      opa = ra; opb = rb; sub = k[0] ? rnd[28] : rnd[27];
      @(negedge clk);
      chk(class_tag(ra, rb, sub), sum, ref_add(ra, rb, sub));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule